// File: doc/BRIEF.md
# Calendar Timekeeper with Keyed Control and Deferred Commit

This block keeps the wall-clock time (seconds, minutes, hours) and the calendar date (day of month, month, a six-bit year count from 1970 and a stored leap flag), and moves them forward by one second on each single-cycle pulse of `tick_1hz`. A host reaches it through a write strobe with a two-bit register select and three always-valid read words: control, time and date. A fourth select loads a 32-bit alarm word. The block keeps the alarm value but does not compare it against the time.

The control word accepts a write only when its upper half carries a fixed unlock key. Writes to the time, date and alarm words do not land at once. Each write starts a commit of `COMMIT_CYC` cycles. A per-word busy bit in the control word stays high while that commit runs. The new value becomes readable in the cycle the busy bit drops. Software is expected to wait until all three busy bits read zero before it writes again.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset the control word reads 0, the time word reads 0 (00:00:00) and the date word reads 0x00000101 (day 1, month 1, year count 0, leap flag 0).
- R2: A control write (wr_sel = 0) updates the oscillator-select bit (control bit 0, also driven on `osc_ext`) only when wr_data[31:16] equals 0x16AA. A control write with any other key leaves the bit unchanged.
- R3: In the control word, only bit 0 (oscillator select), bit 7 (date busy), bit 8 (time busy) and bit 9 (alarm busy) can read as 1. All other bits read 0, even after a keyed write with all ones.
- R4: A time write (wr_sel = 1) sets control bit 8 from the next cycle for exactly COMMIT_CYC cycles. During that window the time word keeps its old value. It shows the new value in the first cycle with bit 8 clear.
- R5: A date write (wr_sel = 2) behaves the same way through control bit 7 and the date word.
- R6: An alarm write (wr_sel = 3) behaves the same way through control bit 9 and `alarm_rd`.
- R7: A write to the time, date or alarm word while that word's busy bit is set is dropped. The pending commit completes with the first value and on its original schedule.
- R8: Time word layout: seconds in bits [5:0], minutes in [13:8], hours in [20:16]. Each tick adds one second. Seconds wrap after 59 into minutes, minutes wrap after 59 into hours, and hours wrap after 23 into the date.
- R9: Date word layout: day in bits [4:0], month (1 to 12) in [11:8], year count in [21:16], leap flag in bit 22. A day carry rolls the day to 1 and advances the month after day 30 in months 4, 6, 9 and 11, and after day 31 in the other non-February months.
- R10: In month 2 the day rolls after day 29 when the leap flag is 1 and after day 28 when it is 0.
- R11: A day carry out of month 12 sets month 1 and adds one to the year count, which wraps from 63 to 0. The leap flag is then recomputed as 1 when (1970 + count) is divisible by 4, that is when count[1:0] is 2, and 0 otherwise.
- R12: Unlisted bits of the time and date words read 0. A written value keeps only its field bits, including the leap flag as written.
- R13: When a commit lands on the same edge as a tick, the committed word takes the written value unchanged. A carry from that tick into a just-committed date is dropped, and a committed time produces no carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 time, 2 date, 3 alarm |
| wr_data | input | 32 | Write data |
| ctrl_rd | output | 32 | Control word: oscillator select and busy bits |
| time_rd | output | 32 | Packed time word |
| date_rd | output | 32 | Packed date word |
| alarm_rd | output | 32 | Committed alarm word |
| osc_ext | output | 1 | 1 selects the external low-speed oscillator |

## Verification
A control write shows on `ctrl_rd` one cycle after its write edge. A tick shows on the time and date words one cycle after the edge that samples it. A time, date or alarm write raises its busy bit one cycle after the write edge and delivers the new value COMMIT_CYC cycles after that edge. The bench drives on falling edges, returns from each write task at the falling edge just after the write edge, and then samples on falling edges. It counts those edges from the same parameter value as the design. This lets it confirm that the old value holds on every edge of the busy window and the new value appears on the first edge after it. The same-edge tick and commit case is placed by stepping exactly COMMIT_CYC-1 falling edges after the write.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'h16AA;

    localparam int CTRL_OSC_BIT  = 0;
    localparam int CTRL_DATE_BSY = 7;
    localparam int CTRL_TIME_BSY = 8;
    localparam int CTRL_ALM_BSY  = 9;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_TIME  = 2'd1;
    localparam logic [1:0] SEL_DATE  = 2'd2;
    localparam logic [1:0] SEL_ALARM = 2'd3;

    typedef struct packed {
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } clock_f_t;

    typedef struct packed {
        logic       leap;
        logic [5:0] year;
        logic [3:0] mon;
        logic [4:0] day;
    } cal_f_t;

    localparam int CLOCK_W = $bits(clock_f_t);
    localparam int CAL_W   = $bits(cal_f_t);

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
        logic [4:0] n;
        case (mon)
            4'd2:                    n = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: n = 5'd30;
            default:                 n = 5'd31;
        endcase
        return n;
    endfunction

    function automatic logic leap_of(input logic [5:0] count);
        return (count[1:0] == 2'b10);
    endfunction

    function automatic logic [31:0] pack_clock(input clock_f_t t);
        return {11'd0, t.hour, 2'd0, t.min, 2'd0, t.sec};
    endfunction

    function automatic logic [31:0] pack_cal(input cal_f_t d);
        return {9'd0, d.leap, d.year, 4'd0, d.mon, 3'd0, d.day};
    endfunction

endpackage

// File: rtl/rtc_commit_slot.sv
module rtc_commit_slot #(
    parameter int W       = 32,
    parameter int LAT     = 4,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] din,
    output logic         busy,
    output logic         fire,
    output logic [W-1:0] pend
);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] LAT_C = CW'(LAT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  data;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (start) begin
            s_d.cnt  = LAT_C;
            s_d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.data <= INIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.cnt != '0);
    assign fire = (s_q.cnt == CW'(1));
    assign pend = s_q.data;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     ld_clock,
    input  clock_f_t clock_in,
    input  logic     ld_cal,
    input  cal_f_t   cal_in,
    output clock_f_t clock_out,
    output cal_f_t   cal_out
);
    typedef struct packed {
        clock_f_t t;
        cal_f_t   d;
    } cal_state_t;

    cal_state_t c_d, c_q;
    logic       day_carry;

    always_comb begin
        c_d       = c_q;
        day_carry = 1'b0;

        if (tick) begin
            if (c_q.t.sec >= 6'd59) begin
                c_d.t.sec = '0;
                if (c_q.t.min >= 6'd59) begin
                    c_d.t.min = '0;
                    if (c_q.t.hour >= 5'd23) begin
                        c_d.t.hour = '0;
                        day_carry  = 1'b1;
                    end else begin
                        c_d.t.hour = c_q.t.hour + 5'd1;
                    end
                end else begin
                    c_d.t.min = c_q.t.min + 6'd1;
                end
            end else begin
                c_d.t.sec = c_q.t.sec + 6'd1;
            end
        end

        if (ld_clock) begin
            c_d.t     = clock_in;
            day_carry = 1'b0;
        end

        if (day_carry) begin
            if (c_q.d.day >= month_len(c_q.d.mon, c_q.d.leap)) begin
                c_d.d.day = 5'd1;
                if (c_q.d.mon >= 4'd12) begin
                    c_d.d.mon  = 4'd1;
                    c_d.d.year = c_q.d.year + 6'd1;
                    c_d.d.leap = leap_of(c_q.d.year + 6'd1);
                end else begin
                    c_d.d.mon = c_q.d.mon + 4'd1;
                end
            end else begin
                c_d.d.day = c_q.d.day + 5'd1;
            end
        end

        if (ld_cal) begin
            c_d.d = cal_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.t      <= '0;
            c_q.d.leap <= 1'b0;
            c_q.d.year <= '0;
            c_q.d.mon  <= 4'd1;
            c_q.d.day  <= 5'd1;
        end else begin
            c_q <= c_d;
        end
    end

    assign clock_out = c_q.t;
    assign cal_out   = c_q.d;

endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
    import rtc_cal_pkg::*;
#(
    parameter int COMMIT_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1hz,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] ctrl_rd,
    output logic [31:0] time_rd,
    output logic [31:0] date_rd,
    output logic [31:0] alarm_rd,
    output logic        osc_ext
);
    typedef struct packed {
        logic osc;
    } ctrl_t;

    ctrl_t    k_d, k_q;
    clock_f_t clock_wr, clock_pend, clock_now;
    cal_f_t   cal_wr, cal_pend, cal_now;
    logic     t_busy, t_fire, d_busy, d_fire, a_busy, a_fire;
    logic [31:0] a_pend;
    logic     wr_time, wr_date, wr_alarm;

    assign clock_wr = '{hour: wr_data[20:16], min: wr_data[13:8], sec: wr_data[5:0]};
    assign cal_wr   = '{leap: wr_data[22], year: wr_data[21:16],
                        mon: wr_data[11:8], day: wr_data[4:0]};

    assign wr_time  = wr_en && (wr_sel == SEL_TIME);
    assign wr_date  = wr_en && (wr_sel == SEL_DATE);
    assign wr_alarm = wr_en && (wr_sel == SEL_ALARM);

    always_comb begin
        k_d = k_q;
        if (wr_en && (wr_sel == SEL_CTRL) && (wr_data[31:16] == UNLOCK_KEY)) begin
            k_d.osc = wr_data[CTRL_OSC_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q <= '0;
        end else begin
            k_q <= k_d;
        end
    end

    rtc_commit_slot #(.W(CLOCK_W), .LAT(COMMIT_CYC), .INIT('0)) i_time_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_time),
        .din   (clock_wr),
        .busy  (t_busy),
        .fire  (t_fire),
        .pend  (clock_pend)
    );

    rtc_commit_slot #(.W(CAL_W), .LAT(COMMIT_CYC), .INIT('0)) i_date_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_date),
        .din   (cal_wr),
        .busy  (d_busy),
        .fire  (d_fire),
        .pend  (cal_pend)
    );

    rtc_commit_slot #(.W(32), .LAT(COMMIT_CYC), .INIT('0)) i_alarm_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_alarm),
        .din   (wr_data),
        .busy  (a_busy),
        .fire  (a_fire),
        .pend  (a_pend)
    );

    logic [31:0] alarm_d, alarm_q;

    always_comb begin
        alarm_d = alarm_q;
        if (a_fire) begin
            alarm_d = a_pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= '0;
        end else begin
            alarm_q <= alarm_d;
        end
    end

    rtc_calendar i_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1hz),
        .ld_clock  (t_fire),
        .clock_in  (clock_pend),
        .ld_cal    (d_fire),
        .cal_in    (cal_pend),
        .clock_out (clock_now),
        .cal_out   (cal_now)
    );

    always_comb begin
        ctrl_rd                = '0;
        ctrl_rd[CTRL_OSC_BIT]  = k_q.osc;
        ctrl_rd[CTRL_DATE_BSY] = d_busy;
        ctrl_rd[CTRL_TIME_BSY] = t_busy;
        ctrl_rd[CTRL_ALM_BSY]  = a_busy;
    end

    assign time_rd  = pack_clock(clock_now);
    assign date_rd  = pack_cal(cal_now);
    assign alarm_rd = alarm_q;
    assign osc_ext  = k_q.osc;

endmodule

// File: rtl/rtc_cal_core_chk.sv
module rtc_cal_core_chk #(
    parameter int COMMIT_CYC = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_1hz,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [15:0] key_in,
    input logic [31:0] ctrl_rd,
    input logic [31:0] time_rd,
    input logic [31:0] date_rd
);
    localparam int RW = $clog2(COMMIT_CYC + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (ctrl_rd[8]) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    a_r3_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd & ~32'h0000_0381) == 32'h0);

    a_r2_badkey_holds_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && key_in != 16'h16AA) |=> $stable(ctrl_rd[0]));

    a_r4_busy_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> ctrl_rd[8]);

    a_r4_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[8] |-> (int'(run_q) < COMMIT_CYC));

    a_r4_busy_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rd[8]) |-> (int'(run_q) == COMMIT_CYC));

    a_r8_second_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !ctrl_rd[8] && time_rd[5:0] < 6'd59)
        |=> (time_rd[5:0] == $past(time_rd[5:0]) + 6'd1));

    a_r11_leap_follows_year: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctrl_rd[7]) && date_rd[21:16] != $past(date_rd[21:16]))
        |-> (date_rd[22] == (date_rd[17:16] == 2'b10)));

    a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((time_rd & ~32'h001F_3F3F) == 32'h0) && ((date_rd & ~32'h007F_0F1F) == 32'h0));

endmodule

bind rtc_cal_core rtc_cal_core_chk #(.COMMIT_CYC(COMMIT_CYC)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .key_in   (wr_data[31:16]),
    .ctrl_rd  (ctrl_rd),
    .time_rd  (time_rd),
    .date_rd  (date_rd)
);

// File: tb/test_rtc_cal_core.sv
module test_rtc_cal_core;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_rd, time_rd, date_rd, alarm_rd;
    logic        osc_ext;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rtc_cal_core #(.COMMIT_CYC(LAT)) i_rtc_cal_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_1hz (tick_1hz),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .ctrl_rd  (ctrl_rd),
        .time_rd  (time_rd),
        .date_rd  (date_rd),
        .alarm_rd (alarm_rd),
        .osc_ext  (osc_ext)
    );

    function automatic logic [31:0] tw(input int h, input int m, input int s);
        return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] dw(input int lp, input int y, input int m, input int d);
        return (32'(lp) << 22) | (32'(y) << 16) | (32'(m) << 8) | 32'(d);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic settle();
        repeat (LAT) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic set_all(input logic [31:0] t, input logic [31:0] d);
        write_reg(2'd1, t); settle();
        write_reg(2'd2, d); settle();
    endtask

    task automatic t_reset();
        chk("R1 ctrl after reset", ctrl_rd, 32'h0);
        chk("R1 time after reset", time_rd, 32'h0);
        chk("R1 date after reset", date_rd, 32'h0000_0101);
    endtask

    task automatic t_ctrl_key();
        write_reg(2'd0, 32'h16AA_0001);
        chk("R2 keyed write sets osc", ctrl_rd, 32'h1);
        chk("R2 osc_ext pin", {31'd0, osc_ext}, 32'h1);
        write_reg(2'd0, 32'h16AB_0000);
        chk("R2 wrong key ignored", ctrl_rd, 32'h1);
        write_reg(2'd0, 32'h0000_0000);
        chk("R2 zero key ignored", ctrl_rd, 32'h1);
        write_reg(2'd0, 32'h16AA_FFFF);
        chk("R3 reserved ctrl bits read zero", ctrl_rd, 32'h1);
        write_reg(2'd0, 32'h16AA_0000);
        chk("R2 keyed write clears osc", ctrl_rd, 32'h0);
    endtask

    task automatic t_time_commit();
        logic [31:0] old_t;
        old_t = time_rd;
        write_reg(2'd1, tw(12, 34, 56));
        for (int i = 0; i < LAT; i++) begin
            chk("R4 time busy during commit", ctrl_rd & 32'h380, 32'h100);
            chk("R4 time held during commit", time_rd, old_t);
            @(negedge clk);
        end
        chk("R4 time busy cleared", ctrl_rd & 32'h380, 32'h0);
        chk("R4 time committed", time_rd, tw(12, 34, 56));
    endtask

    task automatic t_date_commit();
        logic [31:0] old_d;
        old_d = date_rd;
        write_reg(2'd2, dw(0, 5, 7, 15));
        for (int i = 0; i < LAT; i++) begin
            chk("R5 date busy during commit", ctrl_rd & 32'h380, 32'h080);
            chk("R5 date held during commit", date_rd, old_d);
            @(negedge clk);
        end
        chk("R5 date busy cleared", ctrl_rd & 32'h380, 32'h0);
        chk("R5 date committed", date_rd, dw(0, 5, 7, 15));
    endtask

    task automatic t_alarm_commit();
        write_reg(2'd3, 32'hDEAD_BEEF);
        for (int i = 0; i < LAT; i++) begin
            chk("R6 alarm busy during commit", ctrl_rd & 32'h380, 32'h200);
            chk("R6 alarm held during commit", alarm_rd, 32'h0);
            @(negedge clk);
        end
        chk("R6 alarm busy cleared", ctrl_rd & 32'h380, 32'h0);
        chk("R6 alarm committed", alarm_rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_busy_drop();
        write_reg(2'd1, tw(1, 2, 3));
        write_reg(2'd1, tw(4, 5, 6));
        repeat (LAT - 2) @(negedge clk);
        chk("R7 second time write dropped", time_rd, tw(1, 2, 3));
        chk("R7 commit kept its schedule", ctrl_rd & 32'h100, 32'h0);
        write_reg(2'd2, dw(0, 9, 3, 3));
        write_reg(2'd2, dw(1, 10, 4, 4));
        repeat (LAT - 2) @(negedge clk);
        chk("R7 second date write dropped", date_rd, dw(0, 9, 3, 3));
    endtask

    task automatic t_mask();
        set_all(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R12 time unlisted bits zero", time_rd, 32'h001F_3F3F);
        chk("R12 date unlisted bits zero", date_rd, 32'h007F_0F1F);
    endtask

    task automatic t_tick_time();
        set_all(tw(10, 20, 58), dw(0, 3, 6, 10));
        pulse_tick();
        chk("R8 second advance", time_rd, tw(10, 20, 59));
        pulse_tick();
        chk("R8 minute carry", time_rd, tw(10, 21, 0));
        set_all(tw(10, 59, 59), dw(0, 3, 6, 10));
        pulse_tick();
        chk("R8 hour carry", time_rd, tw(11, 0, 0));
        chk("R8 date untouched", date_rd, dw(0, 3, 6, 10));
    endtask

    task automatic roll(input string tag, input logic [31:0] d, input logic [31:0] exp);
        set_all(tw(23, 59, 59), d);
        pulse_tick();
        chk(tag, date_rd, exp);
        chk(tag, time_rd, 32'h0);
    endtask

    task automatic t_month();
        roll("R9 day 30 to 31 in January", dw(0, 4, 1, 30), dw(0, 4, 1, 31));
        roll("R9 January 31 rolls", dw(0, 4, 1, 31), dw(0, 4, 2, 1));
        roll("R9 April 30 rolls", dw(0, 4, 4, 30), dw(0, 4, 5, 1));
        roll("R9 November 30 rolls", dw(0, 4, 11, 30), dw(0, 4, 12, 1));
    endtask

    task automatic t_feb();
        roll("R10 Feb 28 no leap", dw(0, 3, 2, 28), dw(0, 3, 3, 1));
        roll("R10 Feb 28 leap", dw(1, 2, 2, 28), dw(1, 2, 2, 29));
        roll("R10 Feb 29 leap", dw(1, 2, 2, 29), dw(1, 2, 3, 1));
    endtask

    task automatic t_year();
        roll("R11 year into leap", dw(0, 1, 12, 31), dw(1, 2, 1, 1));
        roll("R11 year out of leap", dw(1, 2, 12, 31), dw(0, 3, 1, 1));
        roll("R11 year count wraps", dw(0, 63, 12, 31), dw(0, 0, 1, 1));
    endtask

    task automatic t_commit_vs_tick();
        set_all(tw(8, 0, 0), dw(0, 6, 3, 31));
        write_reg(2'd1, tw(23, 59, 59));
        repeat (LAT - 1) @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        chk("R13 committed time beats tick", time_rd, tw(23, 59, 59));
        chk("R13 no carry from committed time", date_rd, dw(0, 6, 3, 31));
        write_reg(2'd2, dw(0, 7, 5, 10));
        repeat (LAT - 1) @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        chk("R13 tick carry into committed date dropped", date_rd, dw(0, 7, 5, 10));
        chk("R13 time still advanced", time_rd, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_key();
        t_time_commit();
        t_date_commit();
        t_alarm_commit();
        t_busy_drop();
        t_mask();
        t_tick_time();
        t_month();
        t_feb();
        t_year();
        t_commit_vs_tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule